// File: doc/BRIEF.md
# Video Output Format Packer

This block takes one 24-bit pixel per pixel period, made up of three 8-bit components. The components may be R, G and B, or Cr, Y and Cb in the same three positions. It drives three 8-bit output ports, named red, green and blue, in one of three formats chosen by a 2-bit format input. The formats are:

- single-rate 4:4:4 on all 24 pins;
- 16-pin 4:2:2 on the red and green ports;
- a 12-pin double-data-rate 4:4:4 mapping in which each pixel word is split into two 12-bit halves.

In the two narrower formats the blue port carries a secondary double-data-rate 4:2:2 stream.

Double-data-rate output is modelled with a single clock running at twice the pixel rate. A pixel is captured on every second edge. Each pixel then produces a first-half value (the rising-edge data of the real pin) and a second-half value (the falling-edge data). The `out_fall` output marks which half is on the ports. Single-rate data is held unchanged across both halves, so it is stable around the falling edge of the pixel clock.

Chroma is subsampled by keeping Cb from even pixels and Cr from odd pixels. The even/odd count restarts at each line start. The block also registers an output-clock choice and an inversion flag. These go out as one-hot enables and a flag for a clock multiplexer outside the block.

Top module: `vfp_packer`

## Requirements
- R1: While `rst` is high at a clock edge, all three data ports and `out_fall` become 0, `clk_src_en` becomes 4'b0001 and `clk_inv_out` becomes 0.
- R2: A pixel is captured at the first edge after reset release and at every second edge after that. Its first-half value appears on the ports after the next edge, with `out_fall`=0. Its second-half value appears after the edge after that, with `out_fall`=1.
- R3: With `fmt`=2'b00, red=R (`pix_in[23:16]`), green=G (`pix_in[15:8]`) and blue=B (`pix_in[7:0]`) in both halves.
- R4: With `fmt`=2'b01, green carries the luma component `pix_in[15:8]` in both halves. Red carries the chroma in both halves: Cb (`pix_in[7:0]`) on even pixels and Cr (`pix_in[23:16]`) on odd pixels.
- R5: The first pixel after reset, and any pixel captured with `sol`=1, is even. Every other pixel has the opposite parity to the one before it, whatever the format.
- R6: With `fmt`=2'b01 or 2'b10, blue carries the R4 chroma of the pixel in the first half and the luma `pix_in[15:8]` in the second half. Across an even/odd pair this gives the order Cb, Y, Cr, Y.
- R7: With `fmt`=2'b10, the first half puts {G[3:0],B[7:4]} on red and B[3:0] on green[7:4]. The second half puts R[7:0] on red and G[7:4] on green[7:4].
- R8: With `fmt`=2'b10, green[3:0] is 0 in both halves.
- R9: The format code is captured together with its pixel. Code 2'b11 behaves as 2'b00.
- R10: One edge after `clk_sel` is applied, `clk_src_en` is one-hot with bit `clk_sel` set. Bit 0 selects the pixel clock, bit 1 the 90-degree clock, bit 2 the 2x clock and bit 3 the test clock.
- R11: One edge after `clk_inv` is applied, `clk_inv_out` equals it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 24 | Pixel {R/Cr, G/Y, B/Cb}, held for both edges of a pixel period |
| sol | input | 1 | Start of line, sampled with the pixel |
| fmt | input | 2 | Output format: 00 4:4:4, 01 4:2:2, 10 DDR 4:4:4, 11 as 00 |
| clk_sel | input | 2 | Output clock source code |
| clk_inv | input | 1 | Invert output clock request |
| red | output | 8 | Red port data |
| green | output | 8 | Green port data |
| blue | output | 8 | Blue port data |
| out_fall | output | 1 | 0 for first-half data, 1 for second-half data |
| clk_src_en | output | 4 | One-hot clock source enables |
| clk_inv_out | output | 1 | Clock inversion flag |

## Verification
Directed sequences run each format on pixels whose three components and two nibbles differ. This exposes any swapped component, nibble or half in the mappings. A line of 4:2:2 pixels with line starts placed at both even and odd positions shows whether parity restarts correctly and whether Cb precedes Cr. Random pixels then switch format on every pixel, including the reserved code, with random line starts and clock choices. This separates a format taken from the captured pixel from one taken from the live input.

// File: rtl/vfp_pkg.sv
package vfp_pkg;
  typedef enum logic [1:0] {
    FMT_444 = 2'b00,
    FMT_422 = 2'b01,
    FMT_DDR = 2'b10,
    FMT_RSV = 2'b11
  } fmt_e;
endpackage

// File: rtl/vfp_capture.sv
// Pixel capture and line parity tracking. Captures on every second edge.
module vfp_capture #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [3*W-1:0] pix_in,
  input  logic           sol,
  input  logic [1:0]     fmt,
  output logic           half,
  output logic [3*W-1:0] cap_pix,
  output logic           cap_odd,
  output logic [1:0]     cap_fmt
);
  logic odd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      half     <= 1'b0;
      cap_pix  <= '0;
      cap_odd  <= 1'b0;
      cap_fmt  <= 2'b00;
      odd_next <= 1'b0;
    end else begin
      half <= ~half;
      if (!half) begin
        cap_pix <= pix_in;
        cap_fmt <= fmt;
        if (sol) begin
          cap_odd  <= 1'b0;
          odd_next <= 1'b1;
        end else begin
          cap_odd  <= odd_next;
          odd_next <= ~odd_next;
        end
      end
    end
  end
endmodule

// File: rtl/vfp_map.sv
// Combinational port mapping for one half of a pixel period.
module vfp_map
  import vfp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3*W-1:0] pix,
  input  logic           odd,
  input  logic [1:0]     fmt,
  input  logic           fall,
  output logic [W-1:0]   map_r,
  output logic [W-1:0]   map_g,
  output logic [W-1:0]   map_b
);
  localparam int HW = 3 * W / 2;   // width of one DDR half word
  localparam int XW = HW - W;      // bits of the half word on green

  logic [W-1:0]  c_r, c_g, c_b, chroma, second;
  logic [HW-1:0] hword;

  always_comb begin
    c_r    = pix[3*W-1:2*W];
    c_g    = pix[2*W-1:W];
    c_b    = pix[W-1:0];
    chroma = odd ? c_r : c_b;
    second = fall ? c_g : chroma;
    hword  = fall ? pix[3*W-1:HW] : pix[HW-1:0];
    case (fmt_e'(fmt))
      FMT_422: begin
        map_r = chroma;
        map_g = c_g;
        map_b = second;
      end
      FMT_DDR: begin
        map_r = hword[HW-1:XW];
        map_g = {hword[XW-1:0], {(W-XW){1'b0}}};
        map_b = second;
      end
      default: begin
        map_r = c_r;
        map_g = c_g;
        map_b = c_b;
      end
    endcase
  end
endmodule

// File: rtl/vfp_clksel.sv
// Registered one-hot clock source enables and inversion flag.
module vfp_clksel #(
  parameter int N_SRC = 4,
  localparam int SW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    clk_sel,
  input  logic             clk_inv,
  output logic [N_SRC-1:0] clk_src_en,
  output logic             clk_inv_out
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) clk_src_en[i] <= (i == 0);
      else     clk_src_en[i] <= (clk_sel == SW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_inv_out <= 1'b0;
    else     clk_inv_out <= clk_inv;
  end
endmodule

// File: rtl/vfp_packer.sv
module vfp_packer #(
  parameter int W     = 8,
  parameter int N_SRC = 4,
  localparam int PW = 3 * W,
  localparam int SW = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PW-1:0]    pix_in,
  input  logic             sol,
  input  logic [1:0]       fmt,
  input  logic [SW-1:0]    clk_sel,
  input  logic             clk_inv,
  output logic [W-1:0]     red,
  output logic [W-1:0]     green,
  output logic [W-1:0]     blue,
  output logic             out_fall,
  output logic [N_SRC-1:0] clk_src_en,
  output logic             clk_inv_out
);
  logic          half;
  logic [PW-1:0] cap_pix;
  logic          cap_odd;
  logic [1:0]    cap_fmt;
  logic [W-1:0]  map_r, map_g, map_b;
  logic [1:0]    map_fmt;

  vfp_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .pix_in(pix_in), .sol(sol), .fmt(fmt),
    .half(half), .cap_pix(cap_pix), .cap_odd(cap_odd), .cap_fmt(cap_fmt)
  );

  // half=1 means a pixel was just captured: emit its first half next
  vfp_map #(.W(W)) u_map (
    .pix(cap_pix), .odd(cap_odd), .fmt(cap_fmt), .fall(~half),
    .map_r(map_r), .map_g(map_g), .map_b(map_b)
  );

  vfp_clksel #(.N_SRC(N_SRC)) u_clk (
    .clk(clk), .rst(rst), .clk_sel(clk_sel), .clk_inv(clk_inv),
    .clk_src_en(clk_src_en), .clk_inv_out(clk_inv_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      red      <= '0;
      green    <= '0;
      blue     <= '0;
      out_fall <= 1'b0;
      map_fmt  <= 2'b00;
    end else begin
      red      <= map_r;
      green    <= map_g;
      blue     <= map_b;
      out_fall <= ~half;
      map_fmt  <= cap_fmt;
    end
  end
endmodule

// File: rtl/vfp_packer_chk.sv
module vfp_packer_chk #(
  parameter int W     = 8,
  parameter int N_SRC = 4,
  localparam int SW = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     red,
  input logic [W-1:0]     green,
  input logic [W-1:0]     blue,
  input logic             out_fall,
  input logic [1:0]       map_fmt,
  input logic [SW-1:0]    clk_sel,
  input logic             clk_inv,
  input logic [N_SRC-1:0] clk_src_en,
  input logic             clk_inv_out
);
  localparam int XW = 3 * W / 2 - W;

  a_r2_half_alternates: assert property (@(posedge clk) disable iff (rst)
    !rst |=> out_fall != $past(out_fall));

  a_r3_single_rate_hold: assert property (@(posedge clk) disable iff (rst)
    (out_fall && (map_fmt == 2'b00 || map_fmt == 2'b11)) |->
      (red == $past(red) && green == $past(green) && blue == $past(blue)));

  a_r4_422_primary_hold: assert property (@(posedge clk) disable iff (rst)
    (out_fall && map_fmt == 2'b01) |->
      (red == $past(red) && green == $past(green)));

  a_r6_secondary_luma: assert property (@(posedge clk) disable iff (rst)
    (out_fall && map_fmt == 2'b01) |-> blue == green);

  a_r8_ddr_low_zero: assert property (@(posedge clk) disable iff (rst)
    (map_fmt == 2'b10) |-> green[W-XW-1:0] == '0);

  a_r10_src_onehot: assert property (@(posedge clk) disable iff (rst)
    $countones(clk_src_en) == 1);

  a_r10_src_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> clk_src_en[$past(clk_sel)]);

  a_r11_inv_follows: assert property (@(posedge clk) disable iff (rst)
    !rst |=> clk_inv_out == $past(clk_inv));
endmodule

bind vfp_packer vfp_packer_chk #(.W(W), .N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .red(red), .green(green), .blue(blue),
  .out_fall(out_fall), .map_fmt(map_fmt), .clk_sel(clk_sel),
  .clk_inv(clk_inv), .clk_src_en(clk_src_en), .clk_inv_out(clk_inv_out)
);

// File: tb/vfp_packer_tb.sv
`timescale 1ns/1ps
module vfp_packer_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic [23:0] pix_in = '0;
  logic        sol = 0;
  logic [1:0]  fmt = 2'b00;
  logic [1:0]  clk_sel = 2'b00;
  logic        clk_inv = 0;
  logic [7:0]  red, green, blue;
  logic        out_fall;
  logic [3:0]  clk_src_en;
  logic        clk_inv_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // expectation state carried between steps
  bit          nxt_odd = 0;
  bit          have_prev = 0;
  logic [23:0] prev_pix;
  logic [1:0]  prev_fmt;
  bit          prev_odd;
  string       red_tag = "";

  vfp_packer u_dut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .sol(sol), .fmt(fmt),
    .clk_sel(clk_sel), .clk_inv(clk_inv), .red(red), .green(green),
    .blue(blue), .out_fall(out_fall), .clk_src_en(clk_src_en),
    .clk_inv_out(clk_inv_out)
  );

  always #4 clk = ~clk;

  function automatic logic [23:0] expv(logic [1:0] m, logic [23:0] p, bit odd, bit fall);
    logic [7:0]  r, g, b, c;
    logic [11:0] hw;
    r = p[23:16]; g = p[15:8]; b = p[7:0];
    c = odd ? r : b;
    hw = fall ? {r, g[7:4]} : {g[3:0], b};
    case (m)
      2'b01:   return {c, g, fall ? g : c};
      2'b10:   return {hw[11:4], hw[3:0], 4'b0000, fall ? g : c};
      default: return {r, g, b};
    endcase
  endfunction

  function automatic string mtag(logic [1:0] m);
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_ports(logic [1:0] m, logic [23:0] p, bit odd, bit fall, string rtag);
    logic [23:0] e;
    e = expv(m, p, odd, fall);
    chk(rtag == "" ? mtag(m) : rtag, 32'(red), 32'(e[23:16]));
    chk(mtag(m), 32'(green[7:4]), 32'(e[15:12]));
    if (m == 2'b10) chk("R8", 32'(green[3:0]), 32'(e[11:8]));
    else            chk(mtag(m), 32'(green[3:0]), 32'(e[11:8]));
    chk((m == 2'b01 || m == 2'b10) ? "R6" : mtag(m), 32'(blue), 32'(e[7:0]));
    chk("R2", 32'(out_fall), 32'(fall));
  endtask

  task automatic set_clk();
    clk_sel = 2'($urandom_range(0, 3));
    clk_inv = 1'($urandom_range(0, 1));
  endtask

  task automatic chk_clk();
    chk("R10", 32'(clk_src_en), 32'(4'b0001 << clk_sel));
    chk("R11", 32'(clk_inv_out), 32'(clk_inv));
  endtask

  // called at a negedge; presents one pixel and checks both halves of the pipeline
  task automatic step(logic [1:0] m, logic [23:0] p, bit s);
    bit odd;
    string cur_tag;
    cur_tag = red_tag;
    odd = s ? 1'b0 : nxt_odd;
    nxt_odd = !odd;
    pix_in = p; fmt = m; sol = s;
    set_clk();
    @(posedge clk); @(negedge clk);
    if (have_prev) chk_ports(prev_fmt, prev_pix, prev_odd, 1'b1, cur_tag);
    chk_clk();
    set_clk();
    pix_in = $urandom; fmt = 2'($urandom_range(0, 3)); sol = 1'($urandom_range(0, 1));
    @(posedge clk); @(negedge clk);
    chk_ports(m, p, odd, 1'b0, cur_tag);
    chk_clk();
    prev_pix = p; prev_fmt = m; prev_odd = odd; have_prev = 1;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clk_sel = 2'b10; clk_inv = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", 32'({red, green, blue}), 32'h0);
    chk("R1", 32'(out_fall), 32'h0);
    chk("R1", 32'(clk_src_en), 32'h1);
    chk("R1", 32'(clk_inv_out), 32'h0);
    rst = 0;

    // R3, R9: single rate, distinct components
    step(2'b00, 24'hA1B2C3, 1'b0);
    step(2'b11, 24'h5A3C96, 1'b0);
    // R7, R8: DDR split, nibbles all distinct
    step(2'b10, 24'h123456, 1'b0);
    step(2'b10, 24'hFEDCBA, 1'b0);
    // R5, R4, R6: line with starts at even and odd positions
    red_tag = "R5";
    step(2'b01, 24'h11AA22, 1'b1);
    step(2'b01, 24'h33BB44, 1'b0);
    step(2'b01, 24'h55CC66, 1'b0);
    step(2'b01, 24'h77DD88, 1'b1);
    step(2'b01, 24'h99EE00, 1'b0);
    step(2'b01, 24'h12EF34, 1'b1);
    red_tag = "";
    // parity continues across a format change (R5)
    step(2'b00, 24'h0F0F0F, 1'b0);
    step(2'b01, 24'hC0FFEE, 1'b0);

    // random mix of formats, pixels, line starts and clocks
    for (int i = 0; i < 400; i++)
      step(2'($urandom_range(0, 3)), 24'($urandom), 1'($urandom_range(0, 7) == 0));
    step(2'b00, 24'h0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule